// File: doc/BRIEF.md
# Soft-Start Reference Staircase Generator

This block produces the digital reference code that feeds the error amplifier of a voltage-mode step-down regulator while the regulator starts. Once enabled, the code rises from zero to the full setpoint in equal unit steps, one step each time a set number of switching cycles has passed. Because time is measured in switching cycles, the ramp is shorter at a higher switching frequency. At the default configuration there are 64 steps of 32 switching cycles each, so the ramp lasts 2048 switching periods, which is about 8 ms at 250 kHz.

The block counts a one-clock-wide strobe, `sw_tick`, that marks each switching period. When the final step is reached, the code stays at full scale and a done flag rises. Dropping `enable` or pulsing `restart` sends the code and all internal counting back to zero, and the next ramp then starts again from the beginning. The DAC that turns the code into a voltage, the analog amplifier and the PWM comparator belong to other blocks.

Top module: `ss_ref_ramp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `ref_code` is 0 and both `ramping` and `done` are 0, whatever the value of `enable`.
- R2: While `enable` is high and `restart` is low, `ref_code` (an unsigned value, 7 bits at default) goes up by exactly 1 on the clock edge that samples the 32nd counted `sw_tick` of a step. It does not change on any other edge.
- R3: A clock cycle in which `sw_tick` is low never changes `ref_code` or the position inside the current step.
- R4: After 2048 counted ticks (64 steps × 32), `ref_code` equals full scale, 64 (7'b1000000), and `done` is 1. Before that point `done` is 0, and `ref_code` never goes above 64.
- R5: Once full scale is reached, further ticks leave `ref_code` at 64 and `done` at 1 for as long as the block stays enabled.
- R6: A cycle with `enable` low clears `ref_code`, the step position, `ramping` and `done` on the next edge. A ramp started afterwards needs a full 32 ticks before its first step.
- R7: A cycle with `restart` high clears the block in the same way as R6. It takes priority over a `sw_tick` in the same cycle.
- R8: `ramping` is 1 from the edge after the first cycle with `enable` high and `restart` low, up to the edge where `done` rises. It is never high at the same time as `done`.
- R9: While the block is enabled and no restart is requested, `ref_code` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_tick | input | 1 | One-cycle strobe, one per switching period |
| enable | input | 1 | Runs the ramp when high; clears it when low |
| restart | input | 1 | Clears the ramp for one cycle so it starts over |
| ref_code | output | STEP_W+1 | Reference code, 0 up to 2**STEP_W |
| ramping | output | 1 | Ramp is in progress |
| done | output | 1 | Code has reached full scale |

## Verification
Two events can fall in the same cycle: a clear request (`restart` high or `enable` low) and the `sw_tick` that finishes a step, or a tick that arrives after saturation. The bench lines up a restart with the 32nd tick of a step, and separately with a tick in the saturated state. It checks on the following edge that the code is 0 rather than one step higher, and that the next step needs 32 fresh ticks. Every cycle is compared against an arithmetic model: the code is the number of counted ticks divided by 32, capped at 64.

// File: rtl/ss_ref_pkg.sv
`timescale 1ns/1ps
// Package: default sizing shared by the staircase generator and its checker.
// Assumes: the step count and the step dwell are both powers of two.
package ss_ref_pkg;
    // log2 of the number of staircase steps (64 steps)
    localparam int SS_STEP_W_DEF  = 6;
    // log2 of the number of switching ticks per step (32 ticks)
    localparam int SS_DWELL_W_DEF = 5;
endpackage

// File: rtl/ss_dwell_ctr.sv
`timescale 1ns/1ps
// ss_dwell_ctr: counts switching ticks inside one staircase step and raises
// a single-cycle wrap when the last tick of the step is counted.
// Assumes: adv is already gated off while the block is clearing or saturated.
module ss_dwell_ctr #(
    parameter int DWELL_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic wrap
);
    localparam logic [DWELL_W-1:0] LAST = '1;
    localparam logic [DWELL_W-1:0] ONE  = {{(DWELL_W-1){1'b0}}, 1'b1};

    logic [DWELL_W-1:0] cnt;

    // Tick position inside the step; wraps to zero after the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + ONE;
        end
    end

    // The step ends on the tick that finds the counter at its top value.
    always_comb begin
        wrap = adv && (cnt == LAST);
    end
endmodule

// File: rtl/ss_step_ctr.sv
`timescale 1ns/1ps
// ss_step_ctr: holds the reference code, which goes up by one per completed
// step and saturates at full scale (2**STEP_W).
// Assumes: inc is only raised while the code is below full scale.
module ss_step_ctr #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [STEP_W:0]   code,
    output logic              full
);
    localparam logic [STEP_W:0] FULL = {1'b1, {STEP_W{1'b0}}};
    localparam logic [STEP_W:0] ONE  = {{STEP_W{1'b0}}, 1'b1};

    // Reference code register; a clear has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code <= '0;
        end else if (inc && (code != FULL)) begin
            code <= code + ONE;
        end
    end

    // Full-scale detect used for saturation and the done flag.
    always_comb begin
        full = (code == FULL);
    end
endmodule

// File: rtl/ss_ramp_flags.sv
`timescale 1ns/1ps
// ss_ramp_flags: derives the ramping and done status from the enable state
// and the full-scale detect.
// Assumes: full is driven from a register, so both outputs are glitch free.
module ss_ramp_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic full,
    output logic ramping,
    output logic done
);
    logic active_q;

    // Records that the block was enabled and not cleared last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active_q <= 1'b0;
        end else begin
            active_q <= 1'b1;
        end
    end

    // Ramping while active and below full scale; done at full scale.
    always_comb begin
        ramping = active_q && !full;
        done    = full;
    end
endmodule

// File: rtl/ss_ref_ramp.sv
`timescale 1ns/1ps
// ss_ref_ramp: soft-start reference staircase. Counts switching ticks in
// groups of 2**DWELL_W; each group raises the reference code by one, up to
// full scale 2**STEP_W, where the code holds. Disable or restart clears it.
// Assumes: sw_tick is one clk wide per switching period, synchronous to clk.
module ss_ref_ramp
    import ss_ref_pkg::*;
#(
    parameter int STEP_W  = SS_STEP_W_DEF,
    parameter int DWELL_W = SS_DWELL_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_tick,
    input  logic            enable,
    input  logic            restart,
    output logic [STEP_W:0] ref_code,
    output logic            ramping,
    output logic            done
);
    logic clr;
    logic adv;
    logic step_wrap;
    logic at_full;

    // Clear request and tick qualification shared by the counters.
    always_comb begin
        clr = !enable || restart;
        adv = sw_tick && !clr && !at_full;
    end

    ss_dwell_ctr #(.DWELL_W(DWELL_W)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (adv),
        .wrap  (step_wrap)
    );

    ss_step_ctr #(.STEP_W(STEP_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (step_wrap),
        .code  (ref_code),
        .full  (at_full)
    );

    ss_ramp_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .full    (at_full),
        .ramping (ramping),
        .done    (done)
    );
endmodule

// File: rtl/ss_ref_ramp_chk.sv
`timescale 1ns/1ps
// ss_ref_ramp_chk: port-level properties of the staircase generator.
// Assumes: bound to every ss_ref_ramp instance by the bind below.
module ss_ref_ramp_chk #(
    parameter int STEP_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sw_tick,
    input logic            enable,
    input logic            restart,
    input logic [STEP_W:0] ref_code,
    input logic            ramping,
    input logic            done
);
    localparam logic [STEP_W:0] FULL = {1'b1, {STEP_W{1'b0}}};
    localparam logic [STEP_W:0] ONE  = {{STEP_W{1'b0}}, 1'b1};

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !restart) |=>
            (ref_code == $past(ref_code) || ref_code == $past(ref_code) + ONE));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_tick && enable && !restart) |=> $stable(ref_code));

    // R4
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= FULL);

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable && !restart) |=> (done && ref_code == FULL));

    // R6
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ref_code == '0 && !ramping && !done));

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ref_code == '0 && !ramping && !done));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramping && done));
endmodule

bind ss_ref_ramp ss_ref_ramp_chk #(.STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_tick  (sw_tick),
    .enable   (enable),
    .restart  (restart),
    .ref_code (ref_code),
    .ramping  (ramping),
    .done     (done)
);

// File: tb/ss_ref_ramp_test.sv
`timescale 1ns/1ps
// ss_ref_ramp_test: cycle-by-cycle comparison against an arithmetic model,
// where the code is counted ticks / 32, capped at 64.
module ss_ref_ramp_test;
    localparam int DWELL = 32;
    localparam int STEPS = 64;
    localparam int TOTAL = DWELL * STEPS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_tick = 1'b0;
    logic       enable = 1'b0;
    logic       restart = 1'b0;
    logic [6:0] ref_code;
    logic       ramping;
    logic       done;

    int checks = 0;
    int fails = 0;
    int n_ticks = 0;
    bit act = 1'b0;
    int prev_code = 0;

    always #4 clk = ~clk;

    ss_ref_ramp uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_tick  (sw_tick),
        .enable   (enable),
        .restart  (restart),
        .ref_code (ref_code),
        .ramping  (ramping),
        .done     (done)
    );

    task automatic chk(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // One clock: drive inputs at the falling edge, update the model at the
    // rising edge, compare 1 ns later.
    task automatic cyc(input logic t, input logic e, input logic r, input string tag);
        int ec;
        @(negedge clk);
        sw_tick = t; enable = e; restart = r;
        @(posedge clk);
        if (!e || r) begin
            n_ticks = 0; act = 1'b0;
        end else begin
            act = 1'b1;
            if (t && n_ticks < TOTAL) n_ticks++;
        end
        #1;
        ec = n_ticks / DWELL;
        chk({tag, " code"}, int'(ref_code), ec);
        chk({tag, " done"}, int'(done), int'(ec == STEPS));
        chk({tag, " R8 ramping"}, int'(ramping), int'(act && ec != STEPS));
        if (e && !r) begin
            checks++;
            if (int'(ref_code) < prev_code) begin
                fails++;
                $display("FAIL R9 monotonic actual=%0d expected>=%0d", ref_code, prev_code);
            end
        end
        prev_code = int'(ref_code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset dominates an asserted enable and ticks
        enable = 1'b1; sw_tick = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset code", int'(ref_code), 0);
        chk("R1 reset ramping", int'(ramping), 0);
        chk("R1 reset done", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1; enable = 1'b0; sw_tick = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, "R1 after reset");

        // R2/R3/R4: full ramp with a tick every other cycle
        for (int i = 0; i < TOTAL; i++) begin
            cyc(1'b1, 1'b1, 1'b0, "R2 tick");
            cyc(1'b0, 1'b1, 1'b0, "R3 gap");
        end
        chk("R4 full scale", int'(ref_code), 64);
        chk("R4 done", int'(done), 1);

        // R5: saturated ticks keep full scale
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 1'b0, "R5 saturate");
        // R7: restart coinciding with a tick in saturation
        cyc(1'b1, 1'b1, 1'b1, "R7 restart sat");

        // R6: disable mid-ramp, then resume needs a full 32 ticks
        for (int i = 0; i < 5 * DWELL + 7; i++) cyc(1'b1, 1'b1, 1'b0, "R2 dense");
        cyc(1'b1, 1'b0, 1'b0, "R6 disable");
        cyc(1'b1, 1'b0, 1'b0, "R6 held off");
        for (int i = 0; i < DWELL + 1; i++) cyc(1'b1, 1'b1, 1'b0, "R6 resume");

        // R7: restart on the 32nd tick of a step takes priority
        for (int i = 0; i < DWELL - 2; i++) cyc(1'b1, 1'b1, 1'b0, "R2 pre");
        cyc(1'b1, 1'b1, 1'b1, "R7 restart wrap");
        for (int i = 0; i < DWELL; i++) cyc(1'b1, 1'b1, 1'b0, "R7 fresh step");

        // R3/R2: irregular tick pattern to full scale
        for (int i = 0; i < 3 * TOTAL + 200; i++)
            cyc(((i % 3) == 0) || ((i % 7) == 5), 1'b1, 1'b0, "R3 sparse");
        chk("R4 full scale sparse", int'(ref_code), 64);
        cyc(1'b0, 1'b0, 1'b0, "R6 final off");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule